// File: doc/BRIEF.md
# All-Digital Sampled Phase-Locked Loop

This block locks a numerically controlled oscillator to a one-bit square wave that is sampled on strobes of `sample_en`. Each strobe does four things. It advances a 16-bit phase accumulator by the integer part of a fixed-point frequency word. It optionally divides the oscillator down to form a feedback signal. It compares rising edges of that feedback with rising edges of the tracked input in a two-flag phase-frequency detector. It then corrects the frequency word by a proportional-plus-derivative term of the detector error. When the oscillator runs at N times the input rate, it is in lock, so the loop can serve as a frequency multiplier.

The detector is a four-state machine. Its states are `DET_IDLE` (no flag set), `DET_OSC_AHEAD` (feedback flag set), `DET_SIG_AHEAD` (input flag set) and `DET_BOTH` (both set). The transitions are:

- IDLE goes to OSC_AHEAD on a feedback edge alone, to SIG_AHEAD on an input edge alone, and to BOTH on both edges together.
- OSC_AHEAD goes to BOTH on an input edge.
- SIG_AHEAD goes to BOTH on a feedback edge.
- BOTH always returns to IDLE on the next strobe, whatever edges occur on that strobe.

The error is +1 in OSC_AHEAD, -1 in SIG_AHEAD and 0 otherwise. A positive error lowers the frequency word and a negative error raises it.

Top module: `adpll_top`

## Requirements
- R1: When `rst` is high at a clock edge, that edge clears the phase, the detector and the previous-error register, and sets the frequency word to `FREQ_INIT`. The outputs then read `osc_o`=1, `err_o`=0 and `freq_o`=`FREQ_INIT`.
- R2: On each strobe the phase becomes (phase + freq[31:16]) mod 65536, using the frequency word from before that strobe. `osc_o` is 1 exactly when the phase is below 32768.
- R3: A detector flag sets when its input is 1 on the current strobe and was 0 on the previous strobe. The feedback input is the divided oscillator value computed on the same strobe. Both last-sample values start at 0 after reset.
- R4: If both flags were set before a strobe, that strobe clears both flags, even if new edges arrive on it.
- R5: `err_o` equals the feedback flag minus the input flag, in two's complement on 2 bits: 2'b01 is +1, 2'b11 is -1 and 2'b00 is 0.
- R6: On each strobe the frequency word changes by -512·(e + 64·(e − e_prev)). Here e is the error after the strobe and e_prev is the error from the previous strobe.
- R7: The frequency word saturates at 0 and at 2^31−1 instead of wrapping.
- R8: When `sample_en` is 0, no state changes and all outputs hold, whatever `track_i` does.
- R9: With `DIV_N`>1, a counter steps on each oscillator rising edge and wraps at `DIV_N`. The feedback is the oscillator bit gated by that counter being 0 after the strobe's update. The counter resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe; all state advances only when high |
| track_i | input | 1 | Tracked one-bit square wave |
| osc_o | output | 1 | Oscillator bit (phase below half scale) |
| freq_o | output | 32 | Signed frequency word, 16 fraction bits |
| err_o | output | 2 | Detector error, two's complement |

## Verification
The main instance tracks two square waves, one slower and one faster than its starting oscillator. Since the starting frequency lies between them, both signs of error and both directions of frequency correction are exercised. A long stretch with the input held low keeps the feedback flag set, which drives the frequency word down to the zero floor and then parks the phase. A second instance, with a divide-by-two feedback and a word near full scale, receives a sample-rate toggle. This separates correct upper saturation and divider gating from wrap-around. Gaps in the strobe while the input keeps toggling show that nothing moves between samples.

// File: rtl/adpll_pkg.sv
package adpll_pkg;
    typedef enum logic [1:0] {
        DET_IDLE      = 2'd0,
        DET_OSC_AHEAD = 2'd1,
        DET_SIG_AHEAD = 2'd2,
        DET_BOTH      = 2'd3
    } det_state_t;

    localparam int ERR_W = 2;
endpackage

// File: rtl/adpll_nco.sv
module adpll_nco #(
    parameter int PHASE_W = 16,
    parameter int DIV_N   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_en,
    input  logic [PHASE_W-1:0] step_i,
    output logic               fb_now_o,
    output logic               osc_o
);
    localparam int CNT_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_next;
    logic               osc_next;

    // Phase advances with the step from before this strobe
    always_comb begin
        phase_next = phase_q + step_i;
        osc_next   = ~phase_next[PHASE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (sample_en) begin
            phase_q <= phase_next;
        end
    end

    assign osc_o = ~phase_q[PHASE_W-1];

    generate
        if (DIV_N == 1) begin : g_nodiv
            assign fb_now_o = osc_next;
        end else begin : g_div
            logic             osc_last_q;
            logic [CNT_W-1:0] cnt_q;
            logic [CNT_W-1:0] cnt_next;

            always_comb begin
                cnt_next = cnt_q;
                if (osc_next && !osc_last_q) begin
                    cnt_next = (cnt_q == CNT_W'(DIV_N - 1)) ? '0 : cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    osc_last_q <= 1'b0;
                    cnt_q      <= '0;
                end else if (sample_en) begin
                    osc_last_q <= osc_next;
                    cnt_q      <= cnt_next;
                end
            end

            assign fb_now_o = osc_next && (cnt_next == '0);
        end
    endgenerate

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(phase_q)) else $error("phase moved without strobe"); // R8
endmodule

// File: rtl/adpll_pfd.sv
module adpll_pfd
    import adpll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic             fb_i,
    input  logic             sig_i,
    output logic [ERR_W-1:0] err_now_o,
    output logic [ERR_W-1:0] err_o
);
    det_state_t state_q, state_next;
    logic       fb_last_q, sig_last_q;
    logic       fb_edge, sig_edge;

    assign fb_edge  = fb_i  & ~fb_last_q;
    assign sig_edge = sig_i & ~sig_last_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= DET_IDLE;
            fb_last_q  <= 1'b0;
            sig_last_q <= 1'b0;
        end else if (sample_en) begin
            state_q    <= state_next;
            fb_last_q  <= fb_i;
            sig_last_q <= sig_i;
        end
    end

    // Transitions: a full pair always clears first
    always_comb begin
        state_next = state_q;
        unique case (state_q)
            DET_IDLE: begin
                unique case ({fb_edge, sig_edge})
                    2'b00: state_next = DET_IDLE;
                    2'b10: state_next = DET_OSC_AHEAD;
                    2'b01: state_next = DET_SIG_AHEAD;
                    2'b11: state_next = DET_BOTH;
                    default: state_next = DET_IDLE;
                endcase
            end
            DET_OSC_AHEAD: state_next = sig_edge ? DET_BOTH : DET_OSC_AHEAD;
            DET_SIG_AHEAD: state_next = fb_edge  ? DET_BOTH : DET_SIG_AHEAD;
            DET_BOTH:      state_next = DET_IDLE;
            default:       state_next = DET_IDLE;
        endcase
    end

    function automatic logic [ERR_W-1:0] err_of(det_state_t s);
        unique case (s)
            DET_OSC_AHEAD: return 2'b01;
            DET_SIG_AHEAD: return 2'b11;
            default:       return 2'b00;
        endcase
    endfunction

    // Outputs
    always_comb begin
        err_now_o = err_of(state_next);
        err_o     = err_of(state_q);
    end

    AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sample_en && state_q == DET_BOTH) |=> state_q == DET_IDLE) else $error("pair not cleared"); // R4
    AST_DET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(state_q)) else $error("detector moved without strobe"); // R8
endmodule

// File: rtl/adpll_filter.sv
module adpll_filter
    import adpll_pkg::*;
#(
    parameter int                 FREQ_W      = 32,
    parameter int                 DERIV_SHIFT = 6,
    parameter int                 GAIN_SHIFT  = 9,
    parameter logic [FREQ_W-1:0]  FREQ_INIT   = 32'h0040_0000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_en,
    input  logic [ERR_W-1:0]         err_now_i,
    output logic signed [FREQ_W-1:0] freq_o
);
    localparam int FILT_W = DERIV_SHIFT + 4;
    localparam int WIDE_W = FREQ_W + 2;
    localparam logic signed [WIDE_W-1:0] FMAX = {3'b000, {(FREQ_W-1){1'b1}}};
    localparam logic [WIDE_W-1:0] STEP_LIM = WIDE_W'(((2 << DERIV_SHIFT) + 1) << GAIN_SHIFT);

    logic signed [FREQ_W-1:0] freq_q;
    logic signed [FREQ_W-1:0] freq_next;
    logic        [ERR_W-1:0]  lerr_q;
    logic signed [FILT_W-1:0] e_ext, le_ext, filt;
    logic signed [WIDE_W-1:0] f_ext, filt_ext, wide;

    always_comb begin
        e_ext    = {{(FILT_W-ERR_W){err_now_i[ERR_W-1]}}, err_now_i};
        le_ext   = {{(FILT_W-ERR_W){lerr_q[ERR_W-1]}}, lerr_q};
        filt     = e_ext + ((e_ext - le_ext) <<< DERIV_SHIFT);
        f_ext    = {{2{freq_q[FREQ_W-1]}}, freq_q};
        filt_ext = {{(WIDE_W-FILT_W){filt[FILT_W-1]}}, filt};
        wide     = f_ext - (filt_ext <<< GAIN_SHIFT);
        if (wide < 0) begin
            freq_next = '0;
        end else if (wide > FMAX) begin
            freq_next = FMAX[FREQ_W-1:0];
        end else begin
            freq_next = wide[FREQ_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= FREQ_INIT;
            lerr_q <= '0;
        end else if (sample_en) begin
            freq_q <= freq_next;
            lerr_q <= err_now_i;
        end
    end

    assign freq_o = freq_q;

    logic signed [WIDE_W-1:0] chk_diff;
    assign chk_diff = {{2{freq_q[FREQ_W-1]}}, freq_q} - {{2{freq_next[FREQ_W-1]}}, freq_next};

    AST_FREQ_FLOOR: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> freq_q >= 0) else $error("frequency below zero"); // R7
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> (chk_diff <= $signed(STEP_LIM)) && (chk_diff >= -$signed(STEP_LIM))) else $error("step too large"); // R6
    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(freq_q)) else $error("frequency moved without strobe"); // R8
endmodule

// File: rtl/adpll_top.sv
module adpll_top
    import adpll_pkg::*;
#(
    parameter int                FREQ_W    = 32,
    parameter int                FRAC_W    = 16,
    parameter int                DIV_N     = 1,
    parameter logic [FREQ_W-1:0] FREQ_INIT = 32'h0040_0000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_en,
    input  logic                     track_i,
    output logic                     osc_o,
    output logic signed [FREQ_W-1:0] freq_o,
    output logic [1:0]               err_o
);
    localparam int PHASE_W = FREQ_W - FRAC_W;

    logic             fb_now;
    logic [ERR_W-1:0] err_now;
    logic [PHASE_W-1:0] step;

    assign step = freq_o[FREQ_W-1:FRAC_W];

    adpll_nco #(.PHASE_W(PHASE_W), .DIV_N(DIV_N)) u_nco (
        .clk(clk), .rst(rst), .sample_en(sample_en),
        .step_i(step), .fb_now_o(fb_now), .osc_o(osc_o)
    );

    adpll_pfd u_pfd (
        .clk(clk), .rst(rst), .sample_en(sample_en),
        .fb_i(fb_now), .sig_i(track_i),
        .err_now_o(err_now), .err_o(err_o)
    );

    adpll_filter #(.FREQ_W(FREQ_W), .FREQ_INIT(FREQ_INIT)) u_filt (
        .clk(clk), .rst(rst), .sample_en(sample_en),
        .err_now_i(err_now), .freq_o(freq_o)
    );
endmodule

// File: tb/tb_adpll_top.sv
`timescale 1ns/1ps
module tb_adpll_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic sig_a = 1'b0, sig_b = 1'b0;
    logic osc_a, osc_b;
    logic signed [31:0] freq_a, freq_b;
    logic [1:0] err_a, err_b;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    bit seen_zero = 0, seen_max = 0;

    always #4 clk = ~clk;

    adpll_top #(.DIV_N(1), .FREQ_INIT(32'h0040_0000)) dut (
        .clk(clk), .rst(rst), .sample_en(en), .track_i(sig_a),
        .osc_o(osc_a), .freq_o(freq_a), .err_o(err_a));

    adpll_top #(.DIV_N(2), .FREQ_INIT(32'h7FFF_FF00)) dut_div (
        .clk(clk), .rst(rst), .sample_en(en), .track_i(sig_b),
        .osc_o(osc_b), .freq_o(freq_b), .err_o(err_b));

    // behavioural reference, one entry per instance
    int     m_phase[2], m_qr[2], m_qs[2], m_lr[2], m_ls[2], m_lerr[2], m_cnt[2], m_oscl[2];
    longint m_freq[2];
    int     m_div[2]  = '{1, 2};
    longint m_init[2] = '{64'h0040_0000, 64'h7FFF_FF00};

    task automatic chk(string tag, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void m_reset(int k);
        m_phase[k] = 0; m_qr[k] = 0; m_qs[k] = 0; m_lr[k] = 0; m_ls[k] = 0;
        m_lerr[k] = 0; m_cnt[k] = 0; m_oscl[k] = 0; m_freq[k] = m_init[k];
    endfunction

    function automatic void m_step(int k, int s);
        int o, fb, clr, e;
        longint filt;
        m_phase[k] = (m_phase[k] + int'(m_freq[k] / 65536)) % 65536;
        o = (m_phase[k] < 32768) ? 1 : 0;
        if (m_div[k] == 1) fb = o;
        else begin
            if (o == 1 && m_oscl[k] == 0) m_cnt[k] = (m_cnt[k] + 1) % m_div[k];
            m_oscl[k] = o;
            fb = (o == 1 && m_cnt[k] == 0) ? 1 : 0;
        end
        clr = m_qr[k] & m_qs[k];
        m_qs[k] = (m_qs[k] | (s & (1 - m_ls[k]))) & (1 - clr);
        m_qr[k] = (m_qr[k] | (fb & (1 - m_lr[k]))) & (1 - clr);
        m_lr[k] = fb; m_ls[k] = s;
        e = m_qr[k] - m_qs[k];
        filt = e + 64 * (e - m_lerr[k]);
        m_lerr[k] = e;
        m_freq[k] = m_freq[k] - 512 * filt;
        if (m_freq[k] < 0) m_freq[k] = 0;
        if (m_freq[k] > 64'h7FFF_FFFF) m_freq[k] = 64'h7FFF_FFFF;
    endfunction

    task automatic compare();
        chk("R2 osc", longint'(osc_a), (m_phase[0] < 32768) ? 1 : 0);
        chk("R3/R4/R5 err", longint'($signed(err_a)), m_qr[0] - m_qs[0]);
        chk("R6/R7 freq", longint'(freq_a), m_freq[0]);
        chk("R9 osc", longint'(osc_b), (m_phase[1] < 32768) ? 1 : 0);
        chk("R9 err", longint'($signed(err_b)), m_qr[1] - m_qs[1]);
        chk("R9 freq", longint'(freq_b), m_freq[1]);
        if (m_freq[0] == 0) seen_zero = 1;
        if (m_freq[1] == 64'h7FFF_FFFF) seen_max = 1;
    endtask

    // drive away from the edge, update model, sample 2 ns after the edge
    task automatic step(bit e, bit a, bit b);
        en = e; sig_a = a; sig_b = b;
        if (rst) begin m_reset(0); m_reset(1); end
        else if (e) begin m_step(0, int'(a)); m_step(1, int'(b)); end
        @(posedge clk); #2;
        compare();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic sa, sb;
        logic o_h; logic signed [31:0] f_h; logic [1:0] e_h;
        rst = 1'b1;
        step(0, 0, 0); step(1, 1, 1);
        // R1 reset values
        chk("R1 osc", longint'(osc_a), 1);
        chk("R1 err", longint'($signed(err_a)), 0);
        chk("R1 freq", longint'(freq_a), 64'h0040_0000);
        chk("R1 freq div", longint'(freq_b), 64'h7FFF_FF00);
        rst = 1'b0;
        // slow input, period 1600 samples; fast sample-rate toggle on the divided unit
        sb = 0;
        for (int i = 0; i < 8000; i++) begin
            sa = ((i % 1600) < 800);
            sb = ~sb;
            step(1, sa, sb);
        end
        // R8: strobe low while inputs toggle
        o_h = osc_a; f_h = freq_a; e_h = err_a;
        for (int i = 0; i < 60; i++) step(0, i[0], ~i[0]);
        chk("R8 osc hold", longint'(osc_a), longint'(o_h));
        chk("R8 freq hold", longint'(freq_a), longint'(f_h));
        chk("R8 err hold", longint'($signed(err_a)), longint'($signed(e_h)));
        // faster input, period 600 samples, with occasional strobe gaps
        for (int i = 0; i < 9000; i++) begin
            sa = ((i % 600) < 300);
            sb = ~sb;
            step((i % 7) != 3, sa, sb);
        end
        // input held low: feedback flag stays set, word falls to zero
        for (int i = 0; i < 24000; i++) begin
            sb = ~sb;
            step(1, 0, sb);
        end
        chk("R7 floor reached", longint'(seen_zero), 1);
        chk("R7 ceiling reached", longint'(seen_max), 1);
        chk("R7 floor value", longint'(freq_a), 0);
        // R2: at zero frequency the oscillator stays put
        o_h = osc_a;
        for (int i = 0; i < 20; i++) step(1, 0, 0);
        chk("R2 parked osc", longint'(osc_a), longint'(o_h));
        // reset mid-run
        rst = 1'b1; step(1, 1, 1); rst = 1'b0;
        chk("R1 re-reset freq", longint'(freq_a), 64'h0040_0000);
        chk("R1 re-reset err", longint'($signed(err_a)), 0);
        // first strobe after reset: oscillator rising edge sets feedback flag (R3)
        step(1, 0, 0);
        chk("R3 first edge", longint'($signed(err_a)), 1);
        chk("R6 first step", longint'(freq_a), 64'h0040_0000 - 512 * 65);
        // input edge now completes the pair (R4 next strobe clears)
        step(1, 1, 0);
        chk("R4 pair err", longint'($signed(err_a)), 0);
        step(1, 0, 0);
        chk("R4 cleared", longint'($signed(err_a)), 0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule